// File: doc/BRIEF.md
# Link controller reset and clock bring-up sequencer

This block walks a serial-link controller and its PHY out of reset through a fixed, timed series of steps. After a start command it opens the three clock gates one at a time, lifts the PHY power-down, waits, turns on the reference clock, and lets the clocks settle. It then pulses the reset line of the external endpoint and finishes with the release step for the selected variant. Every wait is a parameter counted in clock cycles, and a single down-counter times all of them.

The release step differs by variant. The plain variant releases both resets and reports done at once. The settle variant releases the core reset and waits a settle time before it reports done. The lock-wait variant releases the PHY reset and then samples the PLL-locked input at fixed intervals. If a bounded number of samples all read low, it reports done together with a lock-timeout flag. A shutdown command puts every output back to its reset value from any state, so the next boot starts clean. The endpoint reset level is chosen by a polarity input. A presence input that is low drops the endpoint pulse step entirely. Both inputs are expected to stay static while a sequence is running.

Top module: `link_bringup_seq`

## Requirements
- R1: An accepted start enables the PHY clock in the next cycle. The bus clock follows CLK_GAP_CYC cycles later, and the core clock CLK_GAP_CYC cycles after that. An enable never rises before the one ahead of it in this order.
- R2: The PHY power-down is released CLK_GAP_CYC cycles after the core clock enable. The reference clock is enabled PD_TO_REF_CYC cycles after that release.
- R3: With the endpoint present, the endpoint reset is held at its asserted level from reset onward. It goes to the opposite level REF_STAB_CYC + EP_PULSE_CYC cycles after the reference clock enable. The asserted level is 1 when ep_act_high_i is 1 and 0 otherwise.
- R4: With ep_present_i low, the endpoint reset rests at the inactive level (the inverse of ep_act_high_i). The pulse step is skipped, so the release step begins REF_STAB_CYC cycles after the reference clock enable.
- R5: Variant codes 0 and 3 (plain) release the PHY reset and the core reset and raise done in the cycle the release step begins.
- R6: Variant code 1 (settle) releases the core reset when the release step begins. It releases the PHY reset and raises done SETTLE_CYC cycles later.
- R7: Variant code 2 (lock-wait) releases the PHY reset when the release step begins. It then samples pll_locked_i every POLL_GAP_CYC cycles. The first sample that reads high releases the core reset and raises done.
- R8: In the lock-wait variant, if all POLL_MAX samples read low, the block releases the core reset and raises both done and lock_timeout_o at the last sample.
- R9: A shutdown in any state other than idle returns every output to its reset value in the next cycle. A shutdown in the same cycle as a start wins, and the start is dropped.
- R10: A start is ignored unless the block is idle. This holds both during a sequence and after done. The variant is captured when a start is accepted, and changes to it afterwards have no effect.
- R11: After reset all clock enables, the reference clock enable, done and lock_timeout_o are 0, and phy_pd_o, phy_rst_o and core_rst_o are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin the bring-up sequence (accepted only when idle) |
| shutdown_i | input | 1 | Return to idle, reasserting all resets |
| pll_locked_i | input | 1 | PHY PLL lock status |
| variant_i | input | 2 | Release variant: 0/3 plain, 1 settle, 2 lock-wait |
| ep_present_i | input | 1 | Endpoint reset line exists |
| ep_act_high_i | input | 1 | Endpoint reset asserted level is high |
| phy_clk_en_o | output | 1 | PHY clock gate enable |
| bus_clk_en_o | output | 1 | Bus clock gate enable |
| core_clk_en_o | output | 1 | Core clock gate enable |
| phy_pd_o | output | 1 | PHY power-down |
| ref_clk_en_o | output | 1 | Reference clock enable |
| phy_rst_o | output | 1 | PHY reset, active high |
| core_rst_o | output | 1 | Controller core reset, active high |
| ep_rst_o | output | 1 | Endpoint reset line |
| done_o | output | 1 | Sequence complete |
| lock_timeout_o | output | 1 | PLL lock samples exhausted |

## Verification
The hardest case to reach is a lock that arrives partway through polling. The bench must hold pll_locked_i low past some sample instants and raise it in the exact window before a chosen later sample. Its driver computes the instant of every poll from the release cycle and waits until just after poll n-1 before raising the lock, so that poll n is the first high sample. The timeout case holds the lock low through all POLL_MAX samples. A shutdown lands in the middle of the power-down wait, so the abort is seen as an ordered step back to idle.

// File: rtl/link_seq_pkg.sv
package link_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PHY_CLK,
    ST_BUS_CLK,
    ST_CORE_CLK,
    ST_PD_REL,
    ST_REF_ON,
    ST_EP_PULSE,
    ST_SETTLE,
    ST_LOCK_POLL,
    ST_DONE,
    ST_DONE_TO
  } seq_state_e;

  localparam logic [1:0] VAR_PLAIN  = 2'd0;
  localparam logic [1:0] VAR_SETTLE = 2'd1;
  localparam logic [1:0] VAR_LOCK   = 2'd2;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign expired_o = (cnt_q == '0);

  // an expired timer stays expired until reloaded
  assert_timer_rest_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !load_i) |=> expired_o);

endmodule

// File: rtl/retry_ctr.sv
module retry_ctr #(
  parameter int MAX = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int RW = (MAX > 1) ? $clog2(MAX) : 1;
  localparam logic [RW-1:0] LAST = RW'(MAX - 1);

  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (inc_i && cnt_q != LAST) cnt_q <= cnt_q + RW'(1);
  end

  assign last_o = (cnt_q == LAST);

  assert_retry_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

endmodule

// File: rtl/seq_out_decode.sv
module seq_out_decode
  import link_seq_pkg::*;
(
  input  seq_state_e state_i,
  input  logic       ep_present_i,
  input  logic       ep_act_high_i,
  output logic       phy_clk_en_o,
  output logic       bus_clk_en_o,
  output logic       core_clk_en_o,
  output logic       phy_pd_o,
  output logic       ref_clk_en_o,
  output logic       phy_rst_o,
  output logic       core_rst_o,
  output logic       ep_rst_o,
  output logic       done_o,
  output logic       lock_timeout_o
);

  logic ep_held;

  always_comb begin
    phy_clk_en_o   = (state_i != ST_IDLE);
    bus_clk_en_o   = !(state_i inside {ST_IDLE, ST_PHY_CLK});
    core_clk_en_o  = !(state_i inside {ST_IDLE, ST_PHY_CLK, ST_BUS_CLK});
    phy_pd_o       = (state_i inside {ST_IDLE, ST_PHY_CLK, ST_BUS_CLK, ST_CORE_CLK});
    ref_clk_en_o   = !(state_i inside {ST_IDLE, ST_PHY_CLK, ST_BUS_CLK, ST_CORE_CLK, ST_PD_REL});
    phy_rst_o      = !(state_i inside {ST_LOCK_POLL, ST_DONE, ST_DONE_TO});
    core_rst_o     = !(state_i inside {ST_SETTLE, ST_DONE, ST_DONE_TO});
    done_o         = (state_i inside {ST_DONE, ST_DONE_TO});
    lock_timeout_o = (state_i == ST_DONE_TO);
    ep_held        = ep_present_i &&
                     (state_i inside {ST_IDLE, ST_PHY_CLK, ST_BUS_CLK, ST_CORE_CLK,
                                      ST_PD_REL, ST_REF_ON, ST_EP_PULSE});
    ep_rst_o       = ep_held ? ep_act_high_i : !ep_act_high_i;
  end

endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
  import link_seq_pkg::*;
#(
  parameter int CLK_GAP_CYC   = 16,
  parameter int PD_TO_REF_CYC = 1000,
  parameter int REF_STAB_CYC  = 20000,
  parameter int EP_PULSE_CYC  = 10000000,
  parameter int SETTLE_CYC    = 20000,
  parameter int POLL_GAP_CYC  = 5000,
  parameter int POLL_MAX      = 2000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       shutdown_i,
  input  logic       pll_locked_i,
  input  logic [1:0] variant_i,
  input  logic       ep_present_i,
  input  logic       ep_act_high_i,
  output logic       phy_clk_en_o,
  output logic       bus_clk_en_o,
  output logic       core_clk_en_o,
  output logic       phy_pd_o,
  output logic       ref_clk_en_o,
  output logic       phy_rst_o,
  output logic       core_rst_o,
  output logic       ep_rst_o,
  output logic       done_o,
  output logic       lock_timeout_o
);

  localparam int MAX_DLY = max2(max2(max2(CLK_GAP_CYC, PD_TO_REF_CYC), max2(REF_STAB_CYC, EP_PULSE_CYC)),
                                max2(SETTLE_CYC, POLL_GAP_CYC));
  localparam int CNT_W   = max2($clog2(MAX_DLY), 1);

  // timer is loaded with delay-1 so a state lasts exactly its delay
  localparam logic [CNT_W-1:0] LD_GAP    = CNT_W'(CLK_GAP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PD_REF = CNT_W'(PD_TO_REF_CYC - 1);
  localparam logic [CNT_W-1:0] LD_STAB   = CNT_W'(REF_STAB_CYC - 1);
  localparam logic [CNT_W-1:0] LD_EP     = CNT_W'(EP_PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_SETTLE = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_POLL   = CNT_W'(POLL_GAP_CYC - 1);

  seq_state_e       state_q, state_d;
  logic [1:0]       variant_q;
  logic             tmr_load, tmr_exp;
  logic [CNT_W-1:0] tmr_val;
  logic             rty_clr, rty_inc, rty_last;
  logic             go_release;

  always_comb begin
    state_d    = state_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    rty_clr    = 1'b0;
    rty_inc    = 1'b0;
    go_release = 1'b0;
    if (shutdown_i) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_d = ST_PHY_CLK;  tmr_load = 1'b1; tmr_val = LD_GAP;
        end
        ST_PHY_CLK: if (tmr_exp) begin
          state_d = ST_BUS_CLK;  tmr_load = 1'b1; tmr_val = LD_GAP;
        end
        ST_BUS_CLK: if (tmr_exp) begin
          state_d = ST_CORE_CLK; tmr_load = 1'b1; tmr_val = LD_GAP;
        end
        ST_CORE_CLK: if (tmr_exp) begin
          state_d = ST_PD_REL;   tmr_load = 1'b1; tmr_val = LD_PD_REF;
        end
        ST_PD_REL: if (tmr_exp) begin
          state_d = ST_REF_ON;   tmr_load = 1'b1; tmr_val = LD_STAB;
        end
        ST_REF_ON: if (tmr_exp) begin
          if (ep_present_i) begin
            state_d = ST_EP_PULSE; tmr_load = 1'b1; tmr_val = LD_EP;
          end else begin
            go_release = 1'b1;
          end
        end
        ST_EP_PULSE: if (tmr_exp) go_release = 1'b1;
        ST_SETTLE:   if (tmr_exp) state_d = ST_DONE;
        ST_LOCK_POLL: if (tmr_exp) begin
          if (pll_locked_i)  state_d = ST_DONE;
          else if (rty_last) state_d = ST_DONE_TO;
          else begin
            rty_inc = 1'b1; tmr_load = 1'b1; tmr_val = LD_POLL;
          end
        end
        default: ;
      endcase
      if (go_release) begin
        case (variant_q)
          VAR_SETTLE: begin
            state_d = ST_SETTLE;    tmr_load = 1'b1; tmr_val = LD_SETTLE;
          end
          VAR_LOCK: begin
            state_d = ST_LOCK_POLL; tmr_load = 1'b1; tmr_val = LD_POLL; rty_clr = 1'b1;
          end
          default: state_d = ST_DONE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      variant_q <= VAR_PLAIN;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i && !shutdown_i) variant_q <= variant_i;
    end
  end

  seq_timer #(.W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_exp)
  );

  retry_ctr #(.MAX(POLL_MAX)) u_retry (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (rty_clr),
    .inc_i  (rty_inc),
    .last_o (rty_last)
  );

  seq_out_decode u_dec (
    .state_i        (state_q),
    .ep_present_i   (ep_present_i),
    .ep_act_high_i  (ep_act_high_i),
    .phy_clk_en_o   (phy_clk_en_o),
    .bus_clk_en_o   (bus_clk_en_o),
    .core_clk_en_o  (core_clk_en_o),
    .phy_pd_o       (phy_pd_o),
    .ref_clk_en_o   (ref_clk_en_o),
    .phy_rst_o      (phy_rst_o),
    .core_rst_o     (core_rst_o),
    .ep_rst_o       (ep_rst_o),
    .done_o         (done_o),
    .lock_timeout_o (lock_timeout_o)
  );

  assert_bus_after_phy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_clk_en_o |-> phy_clk_en_o);
  assert_core_after_bus_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_clk_en_o |-> bus_clk_en_o);
  assert_ref_after_power_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_clk_en_o |-> (!phy_pd_o && core_clk_en_o));
  assert_ep_off_before_phy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phy_rst_o && ep_present_i) |-> (ep_rst_o != ep_act_high_i));
  assert_lock_seen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(done_o) && variant_q == VAR_LOCK && !lock_timeout_o) |-> $past(pll_locked_i));
  assert_timeout_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_timeout_o |-> done_o);
  assert_shutdown_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shutdown_i && phy_clk_en_o) |=> (core_rst_o && phy_rst_o && phy_pd_o && !phy_clk_en_o));
  assert_done_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !shutdown_i) |=> done_o);

endmodule

// File: tb/tb_link_bringup_seq.sv
module tb_link_bringup_seq;

  localparam int G = 3, P = 4, S = 6, E = 10, T = 5, Q = 4, M = 5;
  localparam int B_PCK = 9, B_BCK = 8, B_CCK = 7, B_PD = 6, B_REF = 5;
  localparam int B_PRST = 4, B_CRST = 3, B_EP = 2, B_DONE = 1, B_TO = 0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, shutdown = 1'b0, pll = 1'b0;
  logic [1:0] variant = 2'd0;
  logic ep_present = 1'b1, ep_act_high = 1'b1;
  logic phy_clk_en, bus_clk_en, core_clk_en, phy_pd, ref_clk_en;
  logic phy_rst, core_rst, ep_rst, done, lock_to;
  logic [9:0] obs;

  link_bringup_seq #(
    .CLK_GAP_CYC(G), .PD_TO_REF_CYC(P), .REF_STAB_CYC(S), .EP_PULSE_CYC(E),
    .SETTLE_CYC(T), .POLL_GAP_CYC(Q), .POLL_MAX(M)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .shutdown_i(shutdown),
    .pll_locked_i(pll), .variant_i(variant), .ep_present_i(ep_present),
    .ep_act_high_i(ep_act_high), .phy_clk_en_o(phy_clk_en), .bus_clk_en_o(bus_clk_en),
    .core_clk_en_o(core_clk_en), .phy_pd_o(phy_pd), .ref_clk_en_o(ref_clk_en),
    .phy_rst_o(phy_rst), .core_rst_o(core_rst), .ep_rst_o(ep_rst),
    .done_o(done), .lock_timeout_o(lock_to)
  );

  assign obs = {phy_clk_en, bus_clk_en, core_clk_en, phy_pd, ref_clk_en,
                phy_rst, core_rst, ep_rst, done, lock_to};

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         t;
    logic [9:0] v;
    string      tag;
  } item_t;

  item_t      exp_q[$];
  item_t      mon_it;
  logic [9:0] cur, prev;
  int         checks = 0, errors = 0, cut_t = 0;
  bit         mon_en = 1'b0;

  // scoreboard monitor: every output change must match the next expected item
  always @(negedge clk) begin
    if (mon_en && obs !== prev) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1..: unexpected change at cycle %0d: actual %b, expected %b", cyc, obs, prev);
      end else begin
        mon_it = exp_q.pop_front();
        if (mon_it.t != cyc || mon_it.v !== obs) begin
          errors++;
          $display("FAIL %s: actual %b at cycle %0d, expected %b at cycle %0d",
                   mon_it.tag, obs, cyc, mon_it.v, mon_it.t);
        end
      end
    end
    prev = obs;
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) tick();
  endtask

  task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic ev(input int t, input logic [9:0] v, input string tag);
    if (cut_t != 0 && t >= cut_t) return;
    if (v == cur) return;
    if (exp_q.size() > 0 && exp_q[exp_q.size()-1].t == t) begin
      exp_q[exp_q.size()-1].v   = v;
      exp_q[exp_q.size()-1].tag = tag;
    end else begin
      item_t it;
      it.t = t; it.v = v; it.tag = tag;
      exp_q.push_back(it);
    end
    cur = v;
  endtask

  task automatic setb(input int t, input int idx, input logic val, input string tag);
    logic [9:0] v;
    v = cur;
    v[idx] = val;
    ev(t, v, tag);
  endtask

  function automatic logic [9:0] idle_v(input bit a, input bit p);
    logic [9:0] v;
    v = 10'b0001011000;
    v[B_EP] = p ? a : !a;
    return v;
  endfunction

  task automatic set_cfg(input bit a, input bit p);
    tick();
    ep_act_high = a;
    ep_present  = p;
    ev(cyc, idle_v(a, p), "R4");  // idle endpoint level per polarity/presence
  endtask

  task automatic run(input int v, input bit a, input bit p, input int lock_n,
                     input int abort_off, input string vtag);
    int t0, r, fin;
    set_cfg(a, p);
    tick();
    variant = 2'(v);
    start   = 1'b1;
    t0      = cyc + 1;
    cut_t   = (abort_off != 0) ? t0 + abort_off : 0;
    setb(t0,           B_PCK, 1'b1, "R1");
    setb(t0 + G,       B_BCK, 1'b1, "R1");
    setb(t0 + 2*G,     B_CCK, 1'b1, "R1");
    setb(t0 + 3*G,     B_PD,  1'b0, "R2");
    setb(t0 + 3*G + P, B_REF, 1'b1, "R2");
    r = t0 + 3*G + P + S + (p ? E : 0);   // R4: pulse step dropped when absent
    if (p) setb(r, B_EP, !a, "R3");
    case (v)
      1: begin
        setb(r, B_CRST, 1'b0, vtag);
        fin = r + T;
        setb(fin, B_PRST, 1'b0, vtag);
        setb(fin, B_DONE, 1'b1, vtag);
      end
      2: begin
        setb(r, B_PRST, 1'b0, vtag);
        fin = r + ((lock_n != 0) ? lock_n : M) * Q;
        setb(fin, B_CRST, 1'b0, vtag);
        setb(fin, B_DONE, 1'b1, vtag);
        if (lock_n == 0) setb(fin, B_TO, 1'b1, "R8");
      end
      default: begin
        fin = r;
        setb(r, B_PRST, 1'b0, vtag);
        setb(r, B_CRST, 1'b0, vtag);
        setb(r, B_DONE, 1'b1, vtag);
      end
    endcase
    if (abort_off != 0) begin
      cut_t = 0;
      ev(t0 + abort_off, idle_v(a, p), "R9");
      fin = t0 + abort_off;
    end
    tick(); start = 1'b0;
    tick(); start = 1'b1;           // R10: start while busy is ignored
    tick(); start = 1'b0;
    variant = (v == 1) ? 2'd0 : 2'd1; // R10: variant change after capture ignored
    if (abort_off != 0) begin
      wait_until(t0 + abort_off - 1);
      shutdown = 1'b1;
      tick();
      shutdown = 1'b0;
    end else if (v == 2 && lock_n > 0) begin
      wait_until(r + (lock_n - 1) * Q);
      pll = 1'b1;                   // R7: first high sample at poll lock_n
    end
    wait_until(fin + 2);
    check(exp_q.size() == 0, vtag, "pending expected events", exp_q.size(), 0);
    if (abort_off == 0) begin
      tick(); start = 1'b1;         // R10: start after done is ignored
      tick(); start = 1'b0;
      repeat (3) tick();
      check(exp_q.size() == 0 && done, "R10", "done after ignored start", int'(done), 1);
      tick();
      shutdown = 1'b1;
      ev(cyc + 1, idle_v(a, p), "R9");
      tick();
      shutdown = 1'b0;
      repeat (2) tick();
      check(exp_q.size() == 0, "R9", "pending after shutdown", exp_q.size(), 0);
    end
    pll = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    check(obs == idle_v(1'b1, 1'b1), "R11", "output vector in reset", int'(obs), int'(idle_v(1'b1, 1'b1)));
    rst_n = 1'b1;
    tick();
    check(obs == idle_v(1'b1, 1'b1), "R11", "output vector after reset", int'(obs), int'(idle_v(1'b1, 1'b1)));
    cur    = obs;
    prev   = obs;
    mon_en = 1'b1;

    // R9: shutdown together with start in idle drops the start
    tick(); start = 1'b1; shutdown = 1'b1;
    tick(); start = 1'b0; shutdown = 1'b0;
    repeat (4) tick();
    check(obs == idle_v(1'b1, 1'b1), "R9", "idle after start+shutdown", int'(obs), int'(idle_v(1'b1, 1'b1)));

    run(0, 1'b1, 1'b1, 0, 0, "R5");
    run(1, 1'b0, 1'b1, 0, 0, "R6");
    run(2, 1'b1, 1'b1, 3, 0, "R7");
    run(2, 1'b1, 1'b0, 0, 0, "R8");
    run(3, 1'b0, 1'b0, 0, 0, "R5");
    run(1, 1'b1, 1'b1, 0, 3*G + 2, "R9");
    run(2, 1'b0, 1'b1, 1, 0, "R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
    $finish;
  end

endmodule